// File: doc/BRIEF.md
# Modem Handshake Control and Status Registers

This block holds the modem handshake registers of a byte-wide serial port controller. A two-bit control register drives the active-low data-terminal-ready and request-to-send pins. A status register shows the present level of the four active-low modem inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. Each level is shown inverted, so a set bit means the line is asserted. The status register also holds four latched change flags.

Each modem input passes through a two-stage synchronizer and then an edge detector. A change flag sets when its line changes and stays set until software reads the status register. The ring flag is the exception: it sets only on the trailing edge of a ring, when the pin goes from low to high. When the modem-status interrupt enable is high, any set change flag raises an interrupt request. Software reaches both registers through a single-cycle read/write port with a one-bit address.

Top module: `modem_hs_regs`

## Requirements
- R1: After reset, dtr_n and rts_n are 1, the control register reads 0, all four change flags (status bits 3:0) are 0 and irq is 0.
- R2: A write to address 0 stores wdata[0] as the DTR control bit and wdata[1] as the RTS control bit. A read of address 0 returns {6'b0, RTS bit, DTR bit}.
- R3: dtr_n is 0 while the DTR control bit is 1 and is 1 while it is 0. It follows the write at the clock edge that accepts the write.
- R4: rts_n is 0 while the RTS control bit is 1 and is 1 while it is 0. It follows the write at the same edge.
- R5: A read of address 1 returns bit 4 = ~cts_n, bit 5 = ~dsr_n, bit 6 = ~ri_n and bit 7 = ~dcd_n. The pin levels are taken after two synchronizer stages.
- R6: A change in either direction on cts_n, dsr_n or dcd_n sets status bit 0, 1 or 3 respectively. The bit becomes visible three clock edges after the pin changes.
- R7: Status bit 2 sets only when ri_n goes from 0 to 1. A change of ri_n from 1 to 0 leaves it clear.
- R8: A read of address 1 returns the change flags as they were before the read and then clears bits 3:0. Bits 7:4 are not affected by the read.
- R9: A change flag stays set until a status read. If a change is detected at the same clock edge as a status read, its flag stays set after that read.
- R10: irq is 1 exactly when msi_en is 1 and at least one change flag is set. While msi_en is 0, irq stays 0 even if flags are set.
- R11: A write to address 1 has no effect: the control register, dtr_n, rts_n and the status register keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 1 | Register select: 0 = control, 1 = status |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; a status read clears the change flags |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| msi_en | input | 1 | Modem-status interrupt enable |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that the modem pins rest high while reset is applied. The synchronizer and edge-detector history reset to that idle level, so no change flag appears when reset is released. The ring-edge and clear-on-read properties also assume that a pin does not toggle back within the same cycle it changed. The stimulus holds all four pins high through reset and changes them only on falling clock edges. Between changes it leaves at least three cycles, except where several lines are released together on purpose or where a change is timed to meet a status read.

// File: rtl/mhs_pkg.sv
package mhs_pkg;

    localparam int MODEM_W = 4;

    // line index inside every modem vector
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic rts;
        logic dtr;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic [MODEM_W-1:0] delta;
        logic [MODEM_W-1:0] prev;
    } stat_t;

endpackage

// File: rtl/mhs_sync.sv
module mhs_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    // pins idle high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '1;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign sync_out = stg_q[LAST];

endmodule

// File: rtl/mhs_ctrl.sv
module mhs_ctrl
    import mhs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] wbits,
    output ctrl_t             ctrl
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d = ctrl_t'(wbits);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/mhs_status.sv
module mhs_status
    import mhs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODEM_W-1:0] line_n,
    input  logic               rd_clr,
    output logic [MODEM_W-1:0] delta
);

    stat_t              st_d, st_q;
    logic [MODEM_W-1:0] chg;

    always_comb begin
        chg          = line_n ^ st_q.prev;
        // ring flags only its trailing edge: pin low -> high
        chg[IDX_RI]  = line_n[IDX_RI] & ~st_q.prev[IDX_RI];
        st_d.prev    = line_n;
        st_d.delta   = (rd_clr ? '0 : st_q.delta) | chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev  <= '1;
            st_q.delta <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign delta = st_q.delta;

    // R7: ring flag rises only after a synchronized low -> high step
    p_ri_trail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta[IDX_RI]) |-> ($past(line_n[IDX_RI]) && !$past(line_n[IDX_RI], 2)));

    // R8: a read with no new change leaves every flag clear
    p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && $stable(line_n)) |=> (delta == '0));

    // R9: without a read, no set flag is lost
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((delta & $past(delta)) == $past(delta)));

endmodule

// File: rtl/modem_hs_regs.sv
module modem_hs_regs
    import mhs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       msi_en,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       dcd_n,
    output logic       dtr_n,
    output logic       rts_n,
    output logic       irq
);

    localparam int PAD_W = 8 - CTRL_W;

    logic [MODEM_W-1:0] pins_n;
    logic [MODEM_W-1:0] sync_n;
    logic [MODEM_W-1:0] delta;
    ctrl_t              ctrl;
    logic               wr_ctrl;
    logic               rd_clr;
    logic               unused_wbits;

    assign pins_n[IDX_CTS] = cts_n;
    assign pins_n[IDX_DSR] = dsr_n;
    assign pins_n[IDX_RI]  = ri_n;
    assign pins_n[IDX_DCD] = dcd_n;

    assign wr_ctrl      = wr_en && (reg_sel_e'(addr) == SEL_CTRL);
    assign rd_clr       = rd_en && (reg_sel_e'(addr) == SEL_STAT);
    assign unused_wbits = ^wdata[7:CTRL_W];

    mhs_sync #(
        .WIDTH  (MODEM_W),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_n),
        .sync_out (sync_n)
    );

    mhs_ctrl i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wbits   (wdata[CTRL_W-1:0]),
        .ctrl    (ctrl)
    );

    mhs_status i_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_n (sync_n),
        .rd_clr (rd_clr),
        .delta  (delta)
    );

    always_comb begin
        case (reg_sel_e'(addr))
            SEL_CTRL: rdata = {{PAD_W{1'b0}}, ctrl};
            default:  rdata = {~sync_n, delta};
        endcase
    end

    assign dtr_n = ~ctrl.dtr;
    assign rts_n = ~ctrl.rts;
    assign irq   = msi_en && (|delta);

    // R3: DTR pin is the inverse of the written control bit 0
    p_dtr_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr) |=> (dtr_n == !$past(wdata[0])));

    // R4: RTS pin is the inverse of the written control bit 1
    p_rts_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr) |=> (rts_n == !$past(wdata[1])));

    // R11: a status-address write leaves the control pins alone
    p_stat_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr) |=> ($stable(dtr_n) && $stable(rts_n)));

    // R10: the request drops only through disable or a status read
    p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> (!msi_en || $past(rd_en && addr)));

endmodule

// File: tb/test_modem_hs_regs.sv
`timescale 1ns/1ps
module test_modem_hs_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       msi_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       dsr_n = 1'b1;
    logic       ri_n = 1'b1;
    logic       dcd_n = 1'b1;
    logic       dtr_n;
    logic       rts_n;
    logic       irq;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    modem_hs_regs i_modem_hs_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wdata  (wdata),
        .rdata  (rdata),
        .msi_en (msi_en),
        .cts_n  (cts_n),
        .dsr_n  (dsr_n),
        .ri_n   (ri_n),
        .dcd_n  (dcd_n),
        .dtr_n  (dtr_n),
        .rts_n  (rts_n),
        .irq    (irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 dtr_n", {7'b0, dtr_n}, 8'h01);
        chk("R1 rts_n", {7'b0, rts_n}, 8'h01);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        do_read(1'b0, v); chk("R1 ctrl", v, 8'h00);
        do_read(1'b1, v); chk("R1 status", v, 8'h00);
    endtask

    task automatic t_ctrl();
        logic [7:0] v;
        do_write(1'b0, 8'h03);
        chk("R3 dtr low", {7'b0, dtr_n}, 8'h00);
        chk("R4 rts low", {7'b0, rts_n}, 8'h00);
        do_read(1'b0, v); chk("R2 readback 03", v, 8'h03);
        do_write(1'b0, 8'hFE);
        chk("R3 dtr high", {7'b0, dtr_n}, 8'h01);
        chk("R4 rts held low", {7'b0, rts_n}, 8'h00);
        do_read(1'b0, v); chk("R2 readback FE", v, 8'h02);
        do_write(1'b0, 8'h01);
        chk("R4 rts high", {7'b0, rts_n}, 8'h01);
        do_read(1'b0, v); chk("R2 readback 01", v, 8'h01);
    endtask

    task automatic t_stat_write();
        logic [7:0] v;
        do_write(1'b1, 8'hFF);
        do_read(1'b0, v); chk("R11 ctrl kept", v, 8'h01);
        chk("R11 dtr kept", {7'b0, dtr_n}, 8'h00);
        chk("R11 rts kept", {7'b0, rts_n}, 8'h01);
        do_read(1'b1, v); chk("R11 status kept", v, 8'h00);
    endtask

    task automatic t_lines();
        logic [7:0] v;
        @(negedge clk); cts_n = 1'b0; settle();
        do_read(1'b1, v); chk("R6 cts change", v, 8'h11);
        do_read(1'b1, v); chk("R8 cleared, level kept", v, 8'h10);
        @(negedge clk); dsr_n = 1'b0; settle();
        do_read(1'b1, v); chk("R6 dsr change", v, 8'h32);
        do_read(1'b1, v); chk("R8 dsr cleared", v, 8'h30);
        @(negedge clk); dcd_n = 1'b0; settle();
        do_read(1'b1, v); chk("R5 R6 dcd change", v, 8'hB8);
        do_read(1'b1, v); chk("R8 dcd cleared", v, 8'hB0);
        @(negedge clk); cts_n = 1'b1; dsr_n = 1'b1; dcd_n = 1'b1; settle();
        do_read(1'b1, v); chk("R6 rising changes", v, 8'h0B);
        do_read(1'b1, v); chk("R8 all clear", v, 8'h00);
    endtask

    task automatic t_ring();
        logic [7:0] v;
        @(negedge clk); ri_n = 1'b0; settle();
        do_read(1'b1, v); chk("R7 ri fall no flag", v, 8'h40);
        @(negedge clk); ri_n = 1'b1; settle();
        do_read(1'b1, v); chk("R7 ri trailing edge", v, 8'h04);
        do_read(1'b1, v); chk("R8 ri cleared", v, 8'h00);
    endtask

    task automatic t_latency();
        @(negedge clk); dsr_n = 1'b0;
        @(negedge clk);
        addr = 1'b1;
        #1 chk("R5 level after 1 edge", rdata, 8'h00);
        @(negedge clk);
        #1 chk("R5 level after 2 edges", rdata, 8'h20);
        @(negedge clk);
        #1 chk("R6 flag after 3 edges", rdata, 8'h22);
        @(negedge clk); dsr_n = 1'b1; settle();
        begin
            logic [7:0] v;
            do_read(1'b1, v); chk("R9 flag held", v, 8'h02);
            do_read(1'b1, v); chk("R8 cleared", v, 8'h00);
        end
    endtask

    task automatic t_race();
        logic [7:0] v;
        @(negedge clk); cts_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        addr = 1'b1; rd_en = 1'b1;
        #1 chk("R9 flag not yet set at read", {4'b0, rdata[3:0]}, 8'h00);
        @(negedge clk);
        rd_en = 1'b0;
        do_read(1'b1, v); chk("R9 change at read kept", v, 8'h11);
        @(negedge clk); cts_n = 1'b1; settle();
        do_read(1'b1, v); chk("R9 cleanup", v, 8'h01);
        do_read(1'b1, v); chk("R8 cleanup clear", v, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        msi_en = 1'b0;
        @(negedge clk); dcd_n = 1'b0; settle();
        chk("R10 masked", {7'b0, irq}, 8'h00);
        msi_en = 1'b1;
        #1 chk("R10 enabled", {7'b0, irq}, 8'h01);
        do_read(1'b1, v); chk("R10 read value", v, 8'h88);
        #1 chk("R10 cleared by read", {7'b0, irq}, 8'h00);
        @(negedge clk); dcd_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1 chk("R10 not before flag", {7'b0, irq}, 8'h00);
        @(negedge clk);
        #1 chk("R6 R10 irq on third edge", {7'b0, irq}, 8'h01);
        msi_en = 1'b0;
        #1 chk("R10 disable drops", {7'b0, irq}, 8'h00);
        do_read(1'b1, v); chk("R10 flag left", v, 8'h08);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_stat_write();
        t_lines();
        t_ring();
        t_latency();
        t_race();
        t_irq();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule